// File: doc/BRIEF.md
# System Power-Mode Sequencer

This block walks a chip's clocking between four operating modes (sleep, doze, slow and normal) in response to a mode request that software writes into a small control/status register. Two inputs stand in for the real clock sources: a crystal-ready signal and a PLL-lock signal. Going up in mode, the sequencer starts the crystal, waits for it, and switches onto it. Then it starts the PLL, waits for lock, and switches onto that. Going down, it switches back off each source in turn. Every intermediate step is a visible state with a fixed 4-bit code, which software reads back from the same register.

The register has three other jobs. Any write to it raises a soft-reset request for one cycle. It drives a remap-clear output and returns the live remap-status input. It also holds a 3-bit bus clock divider select and a timer reference select. The crystal enable, the PLL enable and a 2-bit clock source select come straight from the current state.

States (status code): SLEEP 0000, DOZE 0001, SLOW 0010, XTAL_WAIT 0011, NORMAL 0100, PLL_WAIT 0110, XTAL_OUT 1001, PLL_OUT 1010, XTAL_IN 1011, PLL_IN 1110.

Transitions:
- SLEEP→DOZE on a wake event or on a non-sleep request.
- DOZE→SLEEP on a sleep request.
- DOZE→XTAL_WAIT on a slow or normal request.
- XTAL_WAIT→XTAL_IN on crystal ready or when the settle count expires.
- XTAL_IN→SLOW.
- SLOW→PLL_WAIT on a normal request.
- SLOW→XTAL_OUT on a doze or sleep request.
- PLL_WAIT→PLL_IN on lock.
- PLL_IN→NORMAL after the switch latency.
- NORMAL→PLL_OUT on any lower request.
- PLL_OUT→SLOW.
- XTAL_OUT→DOZE.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the mode request field (bits [2:0]) reads 001, the status field reads DOZE (0001), and the divider select, timer select, remap-clear and soft-reset outputs are all 0.
- R2: The status field (bits [6:3]) only ever holds one of the ten state codes listed above.
- R3: The request field is decoded as follows: 000 means SLEEP, 001 means DOZE, 01x means SLOW and 1xx means NORMAL. From any stable mode the sequencer settles in the decoded target.
- R4: A write sampled at a clock edge drives soft_rst_req high for exactly the following cycle. With no write, it stays low.
- R5: Bit 8 drives remap_clr. Bit 9 reads the live remap_stat_in. Bits [14:12] drive bus_div_sel and bit 15 drives tmr_ref_sel. Bits [11:10], bit 7 and bits [31:16] read 0, and writes to the status bits have no effect.
- R6: Leaving DOZE upward enters XTAL_WAIT. XTAL_WAIT lasts until xtal_ready is seen, or for XTAL_SETTLE cycles (default 16) if it is not. Then XTAL_IN lasts one cycle, and SLOW follows.
- R7: SLOW with a normal request enters PLL_WAIT and stays there until pll_lock. PLL_IN then lasts SW_LAT cycles (default 3) before NORMAL.
- R8: Going down, NORMAL passes through PLL_OUT to SLOW, SLOW passes through XTAL_OUT to DOZE, and DOZE moves to SLEEP. Each switch state lasts one cycle.
- R9: In SLEEP, a wake event moves to DOZE and reloads the request field with 001. A non-sleep request also moves to DOZE. wake_evt has no effect in other states.
- R10: A request written during a transitional state is held and acted on only once a stable mode is reached.
- R11: Output decode, with clk_src 00 = reference, 01 = crystal, 10 = PLL:
  - xtal_en is 0 only in SLEEP and DOZE.
  - pll_en is 1 only in PLL_WAIT, PLL_IN, NORMAL and PLL_OUT.
  - clk_src is 00 in SLEEP, DOZE, XTAL_WAIT and XTAL_OUT.
  - clk_src is 01 in XTAL_IN, SLOW, PLL_WAIT and PLL_OUT.
  - clk_src is 10 in PLL_IN and NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| xtal_ready | input | 1 | Crystal oscillator is stable |
| pll_lock | input | 1 | PLL is locked |
| wake_evt | input | 1 | Wake event from sleep |
| remap_stat_in | input | 1 | Memory remap status |
| soft_rst_req | output | 1 | One-cycle soft reset request |
| remap_clr | output | 1 | Memory remap clear request |
| bus_div_sel | output | 3 | Bus clock divider select |
| tmr_ref_sel | output | 1 | Timer reference select |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_src | output | 2 | System clock source select |

## Verification
The bench goes after four corner cases:
- **Settle timeout with no crystal-ready.** An off-by-one counter would leave XTAL_WAIT one cycle early or late.
- **Request change while waiting for lock.** A sleep request is written during PLL_WAIT. A design that does not hold it would abandon the wait and never show the single NORMAL cycle before the downward walk.
- **Wake from sleep.** A design that does not reload the request would fall straight back into SLEEP.
- **Reserved and status bits written with random data.** These show up any field that stores writes it should drop.

Random request sequences with random ready and lock timing also confirm the don't-care decode and the source select of every state passed through.

// File: rtl/pwrmode_pkg.sv
`timescale 1ns/1ps
package pwrmode_pkg;

    // Visible state codes; software decodes these from the status field.
    typedef enum logic [3:0] {
        ST_SLEEP     = 4'b0000,
        ST_DOZE      = 4'b0001,
        ST_SLOW      = 4'b0010,
        ST_XTAL_WAIT = 4'b0011,
        ST_NORMAL    = 4'b0100,
        ST_PLL_WAIT  = 4'b0110,
        ST_XTAL_OUT  = 4'b1001,
        ST_PLL_OUT   = 4'b1010,
        ST_XTAL_IN   = 4'b1011,
        ST_PLL_IN    = 4'b1110
    } pm_state_t;

    typedef enum logic [1:0] {
        TGT_SLEEP,
        TGT_DOZE,
        TGT_SLOW,
        TGT_NORMAL
    } pm_target_t;

    typedef enum logic [1:0] {
        SRC_REF  = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_PLL  = 2'b10
    } pm_src_t;

    // Register field positions
    localparam int F_REQ_LO   = 0;
    localparam int F_STAT_LO  = 3;
    localparam int F_RMCLR    = 8;
    localparam int F_RMSTAT   = 9;
    localparam int F_DIV_LO   = 12;
    localparam int F_TMR      = 15;
    localparam int REG_USED_W = 16;

    localparam logic [2:0] REQ_RESET = 3'b001;

    // Highest set bit of the request wins; lower bits are don't-care.
    function automatic pm_target_t decode_req(input logic [2:0] req);
        if (req[2])      return TGT_NORMAL;
        else if (req[1]) return TGT_SLOW;
        else if (req[0]) return TGT_DOZE;
        else             return TGT_SLEEP;
    endfunction

endpackage

// File: rtl/pwrmode_regs.sv
`timescale 1ns/1ps
module pwrmode_regs
    import pwrmode_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake_reload,
    input  logic [3:0]        status,
    input  logic              remap_stat_in,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        mode_req,
    output logic              soft_rst_req,
    output logic              remap_clr,
    output logic [2:0]        div_sel,
    output logic              tmr_sel
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:REG_USED_W], wdata[11:9], wdata[7:3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_req     <= REQ_RESET;
            soft_rst_req <= 1'b0;
            remap_clr    <= 1'b0;
            div_sel      <= 3'b000;
            tmr_sel      <= 1'b0;
        end else begin
            soft_rst_req <= wr_en;
            if (wr_en) begin
                mode_req  <= wdata[F_REQ_LO +: 3];
                remap_clr <= wdata[F_RMCLR];
                div_sel   <= wdata[F_DIV_LO +: 3];
                tmr_sel   <= wdata[F_TMR];
            end else if (wake_reload) begin
                mode_req  <= REQ_RESET;
            end
        end
    end

    always_comb begin
        rdata                  = '0;
        rdata[F_REQ_LO +: 3]   = mode_req;
        rdata[F_STAT_LO +: 4]  = status;
        rdata[F_RMCLR]         = remap_clr;
        rdata[F_RMSTAT]        = remap_stat_in;
        rdata[F_DIV_LO +: 3]   = div_sel;
        rdata[F_TMR]           = tmr_sel;
    end

endmodule

// File: rtl/pwrmode_fsm.sv
`timescale 1ns/1ps
module pwrmode_fsm
    import pwrmode_pkg::*;
#(
    parameter int XTAL_SETTLE = 16,
    parameter int SW_LAT      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pm_target_t target,
    input  logic       xtal_ready,
    input  logic       pll_lock,
    input  logic       wake_evt,
    output pm_state_t  state,
    output logic       wake_reload
);

    localparam int CNT_MAX = (XTAL_SETTLE > SW_LAT) ? XTAL_SETTLE : SW_LAT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(XTAL_SETTLE - 1);
    localparam logic [CNT_W-1:0] LAT_LAST    = CNT_W'(SW_LAT - 1);
    localparam logic [CNT_W-1:0] CNT_TOP     = CNT_W'(CNT_MAX);

    pm_state_t       state_nxt;
    logic [CNT_W-1:0] dwell;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DOZE;
        else        state <= state_nxt;
    end

    // Cycles spent in the current state, cleared on every change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dwell <= '0;
        else if (state_nxt != state) dwell <= '0;
        else if (dwell != CNT_TOP)   dwell <= dwell + 1'b1;
    end

    // Next state: targets are only consulted in the four stable modes
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SLEEP: begin
                if (wake_evt || target != TGT_SLEEP) state_nxt = ST_DOZE;
            end
            ST_DOZE: begin
                if (target == TGT_SLEEP)                             state_nxt = ST_SLEEP;
                else if (target == TGT_SLOW || target == TGT_NORMAL) state_nxt = ST_XTAL_WAIT;
            end
            ST_XTAL_WAIT: begin
                if (xtal_ready || dwell == SETTLE_LAST) state_nxt = ST_XTAL_IN;
            end
            ST_XTAL_IN:  state_nxt = ST_SLOW;
            ST_SLOW: begin
                if (target == TGT_NORMAL)                            state_nxt = ST_PLL_WAIT;
                else if (target == TGT_DOZE || target == TGT_SLEEP)  state_nxt = ST_XTAL_OUT;
            end
            ST_PLL_WAIT: begin
                if (pll_lock) state_nxt = ST_PLL_IN;
            end
            ST_PLL_IN: begin
                if (dwell == LAT_LAST) state_nxt = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (target != TGT_NORMAL) state_nxt = ST_PLL_OUT;
            end
            ST_PLL_OUT:  state_nxt = ST_SLOW;
            ST_XTAL_OUT: state_nxt = ST_DOZE;
            default:     state_nxt = ST_DOZE;
        endcase
    end

    assign wake_reload = (state == ST_SLEEP) && wake_evt;

endmodule

// File: rtl/pwrmode_outdec.sv
`timescale 1ns/1ps
module pwrmode_outdec
    import pwrmode_pkg::*;
(
    input  pm_state_t   state,
    output logic        xtal_en,
    output logic        pll_en,
    output logic [1:0]  clk_src
);

    pm_src_t src;

    always_comb begin
        xtal_en = 1'b1;
        pll_en  = 1'b0;
        src     = SRC_REF;
        unique case (state)
            ST_SLEEP, ST_DOZE: begin
                xtal_en = 1'b0;
            end
            ST_XTAL_WAIT, ST_XTAL_OUT: begin
                src = SRC_REF;
            end
            ST_XTAL_IN, ST_SLOW: begin
                src = SRC_XTAL;
            end
            ST_PLL_WAIT, ST_PLL_OUT: begin
                pll_en = 1'b1;
                src    = SRC_XTAL;
            end
            ST_PLL_IN, ST_NORMAL: begin
                pll_en = 1'b1;
                src    = SRC_PLL;
            end
            default: begin
                xtal_en = 1'b0;
            end
        endcase
    end

    assign clk_src = src;

endmodule

// File: rtl/pwrmode_ctrl.sv
`timescale 1ns/1ps
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int XTAL_SETTLE = 16,
    parameter int SW_LAT      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xtal_ready,
    input  logic              pll_lock,
    input  logic              wake_evt,
    input  logic              remap_stat_in,
    output logic              soft_rst_req,
    output logic              remap_clr,
    output logic [2:0]        bus_div_sel,
    output logic              tmr_ref_sel,
    output logic              xtal_en,
    output logic              pll_en,
    output logic [1:0]        clk_src
);

    pm_state_t  cur_state;
    pm_target_t tgt;
    logic [2:0] mode_req;
    logic       wake_reload;

    assign tgt = decode_req(mode_req);

    pwrmode_regs #(.DATA_W(DATA_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr),
        .wdata         (reg_wdata),
        .wake_reload   (wake_reload),
        .status        (cur_state),
        .remap_stat_in (remap_stat_in),
        .rdata         (reg_rdata),
        .mode_req      (mode_req),
        .soft_rst_req  (soft_rst_req),
        .remap_clr     (remap_clr),
        .div_sel       (bus_div_sel),
        .tmr_sel       (tmr_ref_sel)
    );

    pwrmode_fsm #(.XTAL_SETTLE(XTAL_SETTLE), .SW_LAT(SW_LAT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .target      (tgt),
        .xtal_ready  (xtal_ready),
        .pll_lock    (pll_lock),
        .wake_evt    (wake_evt),
        .state       (cur_state),
        .wake_reload (wake_reload)
    );

    pwrmode_outdec u_dec (
        .state   (cur_state),
        .xtal_en (xtal_en),
        .pll_en  (pll_en),
        .clk_src (clk_src)
    );

endmodule

// File: rtl/pwrmode_chk.sv
`timescale 1ns/1ps
module pwrmode_chk
    import pwrmode_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              soft_rst_req,
    input logic [3:0]        status,
    input logic              xtal_en,
    input logic              pll_en,
    input logic [1:0]        clk_src,
    input logic [DATA_W-1:0] reg_rdata
);

    // R4
    soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> soft_rst_req);

    // R4
    soft_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(reg_wr));

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {ST_SLEEP, ST_DOZE, ST_SLOW, ST_XTAL_WAIT, ST_NORMAL,
                       ST_PLL_WAIT, ST_XTAL_OUT, ST_PLL_OUT, ST_XTAL_IN, ST_PLL_IN});

    // R11
    pll_needs_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> xtal_en);

    // R11
    src_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'b10) |-> pll_en);

    // R11
    src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src != 2'b11);

    // R8
    normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_NORMAL) |=> (status == ST_NORMAL || status == ST_PLL_OUT));

    // R6
    xtal_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_XTAL_IN) |=> (status == ST_SLOW));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[11:10] == 2'b00 && reg_rdata[7] == 1'b0);

endmodule

bind pwrmode_ctrl pwrmode_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .soft_rst_req (soft_rst_req),
    .status       (cur_state),
    .xtal_en      (xtal_en),
    .pll_en       (pll_en),
    .clk_src      (clk_src),
    .reg_rdata    (reg_rdata)
);

// File: tb/sim_pwrmode_ctrl.sv
`timescale 1ns/1ps
module sim_pwrmode_ctrl;

    localparam int SETTLE = 16;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xtal_ready = 1'b0;
    logic        pll_lock = 1'b0;
    logic        wake_evt = 1'b0;
    logic        remap_stat_in = 1'b0;
    logic        soft_rst_req, remap_clr, tmr_ref_sel, xtal_en, pll_en;
    logic [2:0]  bus_div_sel;
    logic [1:0]  clk_src;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwrmode_ctrl #(.DATA_W(32), .XTAL_SETTLE(SETTLE), .SW_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xtal_ready(xtal_ready), .pll_lock(pll_lock),
        .wake_evt(wake_evt), .remap_stat_in(remap_stat_in),
        .soft_rst_req(soft_rst_req), .remap_clr(remap_clr),
        .bus_div_sel(bus_div_sel), .tmr_ref_sel(tmr_ref_sel),
        .xtal_en(xtal_en), .pll_en(pll_en), .clk_src(clk_src)
    );

    wire [3:0] stat = reg_rdata[6:3];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_src(input logic [3:0] s);
        case (s)
            4'h0, 4'h1, 4'h3, 4'h9: return 2'b00;
            4'h2, 4'hB, 4'h6, 4'hA: return 2'b01;
            4'h4, 4'hE:             return 2'b10;
            default:                return 2'b11;
        endcase
    endfunction

    function automatic logic exp_xen(input logic [3:0] s);
        return !(s == 4'h0 || s == 4'h1);
    endfunction

    function automatic logic exp_pen(input logic [3:0] s);
        return (s == 4'h6 || s == 4'hE || s == 4'h4 || s == 4'hA);
    endfunction

    function automatic logic [3:0] exp_target(input logic [2:0] r);
        if (r[2])      return 4'h4;
        else if (r[1]) return 4'h2;
        else if (r[0]) return 4'h1;
        else           return 4'h0;
    endfunction

    function automatic logic exp_legal(input logic [3:0] s);
        return s inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h9, 4'hA, 4'hB, 4'hE};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] d, input logic rm, input logic [3:0] st);
        logic [31:0] v;
        v        = '0;
        v[2:0]   = d[2:0];
        v[6:3]   = st;
        v[8]     = d[8];
        v[9]     = rm;
        v[15:12] = d[15:12];
        return v;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic check_outs(input string tag);
        check({"R11 xtal_en ", tag}, 32'(xtal_en), 32'(exp_xen(stat)));
        check({"R11 pll_en ", tag},  32'(pll_en),  32'(exp_pen(stat)));
        check({"R11 clk_src ", tag}, 32'(clk_src), 32'(exp_src(stat)));
        check({"R2 legal code ", tag}, 32'(exp_legal(stat)), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] seq [10];
        int n;
        void'($urandom(32'h5eed_1234));

        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 request", 32'(reg_rdata[2:0]), 32'd1);
        check("R1 status", 32'(stat), 32'h1);
        check("R1 div/tmr/remap", 32'({bus_div_sel, tmr_ref_sel, remap_clr}), 32'd0);
        check("R1 soft reset", 32'(soft_rst_req), 32'd0);
        check_outs("reset");

        // R6 settle timeout path to SLOW, R4 soft reset pulse
        wr(32'h0000_0002);
        check("R4 pulse high", 32'(soft_rst_req), 32'd1);
        check("R10 status before move", 32'(stat), 32'h1);
        tick();
        check("R4 pulse low", 32'(soft_rst_req), 32'd0);
        check("R6 enter xtal wait", 32'(stat), 32'h3);
        check_outs("xtal wait");
        n = 0;
        while (stat == 4'h3 && n < 100) begin
            n++;
            tick();
        end
        check("R6 settle length", 32'(n), 32'(SETTLE));
        check("R6 xtal switch-in", 32'(stat), 32'hB);
        check_outs("xtal in");
        tick();
        check("R6 slow reached", 32'(stat), 32'h2);
        check_outs("slow");

        // R7 PLL wait, R10 held request during PLL_WAIT
        wr(32'h0000_0004);
        tick();
        check("R7 enter pll wait", 32'(stat), 32'h6);
        repeat (5) tick();
        check("R7 waits for lock", 32'(stat), 32'h6);
        wr(32'h0000_0000);
        check("R10 held during wait", 32'(stat), 32'h6);
        tick();
        check("R10 still held", 32'(stat), 32'h6);
        pll_lock = 1'b1;
        tick();
        pll_lock = 1'b0;
        seq = '{4'hE, 4'hE, 4'hE, 4'h4, 4'hA, 4'h2, 4'h9, 4'h1, 4'h0, 4'h0};
        foreach (seq[i]) begin
            check($sformatf("R7 R8 R10 step %0d", i), 32'(stat), 32'(seq[i]));
            check_outs("walk");
            tick();
        end

        // R9 wake from sleep reloads request
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        check("R9 wake to doze", 32'(stat), 32'h1);
        check("R9 request reload", 32'(reg_rdata[2:0]), 32'd1);
        tick();
        check("R9 stays doze", 32'(stat), 32'h1);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        check("R9 wake ignored in doze", 32'(stat), 32'h1);

        // R9 request exit from sleep, R6 ready shortcut, R3 01x decode
        wr(32'h0000_0000);
        tick();
        check("R8 doze to sleep", 32'(stat), 32'h0);
        wr(32'h0000_0003);
        check("R9 sleep until edge", 32'(stat), 32'h0);
        tick();
        check("R9 request exits sleep", 32'(stat), 32'h1);
        xtal_ready = 1'b1;
        tick();
        check("R6 xtal wait with ready", 32'(stat), 32'h3);
        tick();
        check("R6 ready shortcut", 32'(stat), 32'hB);
        tick();
        check("R3 01x is slow", 32'(stat), 32'h2);
        xtal_ready = 1'b0;
        wr(32'h0000_0001);
        tick();
        check("R8 xtal switch-out", 32'(stat), 32'h9);
        check_outs("xtal out");
        tick();
        check("R8 back in doze", 32'(stat), 32'h1);

        // R5 random register fields while holding DOZE
        for (int k = 0; k < 20; k++) begin
            logic [31:0] d;
            d = $urandom;
            d[2:0] = 3'b001;
            remap_stat_in = 1'($urandom);
            wr(d);
            check("R5 readback", reg_rdata, exp_rd(d, remap_stat_in, 4'h1));
            check("R5 outputs", 32'({remap_clr, bus_div_sel, tmr_ref_sel}),
                  32'({d[8], d[14:12], d[15]}));
            remap_stat_in = ~remap_stat_in;
            #1;
            check("R5 live remap status", 32'(reg_rdata[9]), 32'(remap_stat_in));
        end

        // R3 random requests with random ready/lock timing
        for (int k = 0; k < 40; k++) begin
            logic [2:0]  r;
            logic [3:0]  goal;
            int          w;
            r    = 3'($urandom);
            goal = exp_target(r);
            wr({$urandom} & 32'hF100 | 32'(r));
            w = 0;
            while (stat != goal && w < 300) begin
                xtal_ready = ($urandom % 4) == 0;
                pll_lock   = ($urandom % 3) == 0;
                check_outs("random");
                w++;
                tick();
            end
            xtal_ready = 1'b0;
            pll_lock   = 1'b0;
            check($sformatf("R3 request %0b reached", r), 32'(stat), 32'(goal));
            tick();
            check($sformatf("R3 request %0b stable", r), 32'(stat), 32'(goal));
            check_outs("settled");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule